// File: doc/BRIEF.md
# Multiplexed Burst Bus Controller

This block sits between a core-side request port and an external bus on which address and data share the same 32 wires. A request names a start address, a transfer count of one to four, a physical bus width, a set of byte lanes, and a direction. The controller drives one address cycle and then one data cycle per transfer. It samples a single active-low ready/recover input that stretches data cycles with wait states. After the last transfer, the same input holds the bus in recovery until it reads high.

On 16-bit and 8-bit buses, some of the active-low byte-enable pins are reused as low address bits. The partial address advances with each accepted transfer. The controller can keep the bus locked across several requests that form one atomic sequence. It also hands the bus to an external master on a hold request, floating its outputs and acknowledging, but never while a lock is open.

The core sees a ready signal while the bus is idle and free. After the final transfer it sees a one-cycle done pulse, together with the read words.

Top module: `mbus_ctrl`

## Requirements
- R1: In the cycle after a request is accepted (the address cycle), `ads_n` is low, `ale` is high, `ad_oe` is high, and `ad_out` carries `req_addr[31:2]` in bits 31:2 with the transfer count minus one (`req_last`) in bits 1:0. This lasts exactly one cycle.
- R2: The cycle after the address cycle is always a data cycle: `ale` and `ads_n` return inactive and `den_n` goes low.
- R3: In a data cycle, `rdy_n` high at the clock edge repeats the same transfer (wait state). `rdy_n` low completes it. A read stores `ad_in` into 32-bit slot k of `rdata` for transfer k. A write drives slot k of `req_wdata` on `ad_out`, with `ad_oe` high.
- R4: After the last transfer, `den_n` goes high and the bus stays in recovery, with no address cycle and `req_ready` low, until `rdy_n` is sampled high. The bus then returns to idle.
- R5: `blast_n` is low during every data cycle of the final transfer, including its wait states, and high otherwise.
- R6: `wr` and `dtr` are 1 for a write and 0 for a read during the address and data cycles, and 0 elsewhere. `den_n` is low exactly in data cycles, and `dtr` does not change while `den_n` stays low.
- R7: Byte enables depend on `req_width` (0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit), where `pa` is the partial address of the current transfer. On a 32-bit bus, `be_n` is the inverse of `req_lanes`. On a 16-bit bus, `be_n[3]` = !lanes[1], `be_n[2]` = 1, `be_n[1]` = pa[1], and `be_n[0]` = !lanes[0]. On an 8-bit bus, `be_n[3:2]` = 11 and `be_n[1:0]` = pa[1:0]. `be_n` is 4'hF outside address and data cycles.
- R8: The partial address is `req_addr[3:0]` plus k times the bus width in bytes, modulo 16, for transfer k. `pa_hi` shows its bits 3:2 in the address and data cycles and 0 elsewhere. Lane enables stay constant through a burst.
- R9: `lock_n` goes low in the address cycle of a request with `req_lock` set. It stays low across requests until the final data cycle of a request with `req_lock_end` set, where it goes high. `holda` is never high while `lock_n` is low.
- R10: In idle with `hold` high and no lock open, `holda` is high from the next cycle, with `ctl_oe` and `ad_oe` low. One cycle after `hold` falls, `holda` is low and the bus is idle.
- R11: `req_ready` is high only in idle when a hold is not about to be granted. A request seen while it is low stays pending. `done` is a one-cycle pulse in the first cycle after the last transfer.
- R12: Synchronous reset, even mid-transfer, returns the bus to idle with `ads_n`, `den_n`, `blast_n`, `lock_n` high, `be_n` = 4'hF, `ale`, `wr`, `dtr`, `holda`, `done` low and `ctl_oe` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Start byte address |
| req_last | input | 2 | Number of transfers minus one |
| req_width | input | 2 | Physical bus width: 0 = 8, 1 = 16, else 32 bits |
| req_lanes | input | 4 | Active-high byte lane mask |
| req_lock | input | 1 | Request belongs to an atomic sequence |
| req_lock_end | input | 1 | Request closes the atomic sequence |
| req_wdata | input | 128 | Write words, slot k for transfer k |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 128 | Read words, slot k from transfer k |
| ad_in | input | 32 | Address/data bus, incoming value |
| ad_out | output | 32 | Address/data bus, driven value |
| ad_oe | output | 1 | Address/data bus driver enable |
| ctl_oe | output | 1 | Control pin driver enable (low in hold) |
| ads_n | output | 1 | Address strobe, active low |
| ale | output | 1 | Address latch enable, active high |
| be_n | output | 4 | Byte enables / low address bits, active low |
| pa_hi | output | 2 | Partial address bits 3:2 |
| wr | output | 1 | Write/read indicator |
| dtr | output | 1 | Transceiver direction, 1 = transmit |
| den_n | output | 1 | Data enable, active low |
| blast_n | output | 1 | Final transfer marker, active low |
| lock_n | output | 1 | Atomic sequence in progress, active low |
| rdy_n | input | 1 | Ready in data cycles, recover in recovery |
| hold | input | 1 | External master requests the bus |
| holda | output | 1 | Bus granted to external master |

## Verification
Two functions meet in one cycle in this block: granting the bus to an outside master, and closing an atomic lock. The bench raises `hold` while a locked sequence is still open and keeps it high through the sequence's closing write. `holda` must stay low while `lock_n` is low, including the idle gap between the locked requests. It must rise only in the cycle after the bus returns to idle with the lock released. A second case puts a core request and a hold request in the same idle cycle. The hold must win, and the request must wait and start its address cycle only after `holda` falls.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
    localparam int unsigned DW    = 32;
    localparam int unsigned SZW   = 2;
    localparam int unsigned NBEAT = 1 << SZW;
    localparam int unsigned LANES = DW / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_RECOV,
        ST_HOLD
    } bus_st_e;

    typedef struct packed {
        logic             write;
        logic             lock_end;
        logic [1:0]       width;
        logic [SZW-1:0]   last;
        logic [LANES-1:0] lanes;
        logic [DW-1:0]    addr;
    } req_t;

    function automatic logic [1:0] step_shift(input logic [1:0] width);
        case (width)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic [3:0] be_pins(input logic [1:0] width,
                                           input logic [3:0] lanes,
                                           input logic [1:0] pa_lo);
        case (width)
            2'd0:    return {2'b11, pa_lo};
            2'd1:    return {~lanes[1], 1'b1, pa_lo[1], ~lanes[0]};
            default: return ~lanes;
        endcase
    endfunction
endpackage

// File: rtl/mbus_fsm.sv
module mbus_fsm
    import mbus_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    input  req_t           req_in,
    input  logic           req_lock,
    input  logic           rdy_n,
    input  logic           hold,
    output bus_st_e        state,
    output logic [SZW-1:0] beat,
    output req_t           cur,
    output logic           lock_q,
    output logic           done,
    output logic           req_ready,
    output logic           xfer,
    output logic           last_beat
);
    assign last_beat = (beat == cur.last);
    assign xfer      = (state == ST_DATA) && !rdy_n;
    assign req_ready = (state == ST_IDLE) && !(hold && !lock_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            beat   <= '0;
            cur    <= '0;
            lock_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (hold && !lock_q) begin
                        state <= ST_HOLD;
                    end else if (req_valid) begin
                        state <= ST_ADDR;
                        cur   <= req_in;
                        beat  <= '0;
                        if (req_lock) lock_q <= 1'b1;
                    end
                end
                ST_ADDR: state <= ST_DATA;
                ST_DATA: begin
                    if (!rdy_n) begin
                        beat <= beat + 1'b1;
                        if (last_beat) begin
                            state <= ST_RECOV;
                            done  <= 1'b1;
                            if (cur.lock_end) lock_q <= 1'b0;
                        end
                    end
                end
                ST_RECOV: if (rdy_n) state <= ST_IDLE;
                ST_HOLD:  if (!hold) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    AST_WAIT_REPEAT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && rdy_n) |=> (state == ST_DATA && $stable(beat))); // R3
    AST_RECOV_WAIT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RECOV && !rdy_n) |=> (state == ST_RECOV)); // R4
    AST_NO_GRANT_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && lock_q) |=> (state != ST_HOLD)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11
endmodule

// File: rtl/mbus_lane.sv
module mbus_lane
    import mbus_pkg::*;
(
    input  bus_st_e          state,
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       width,
    input  logic [LANES-1:0] lanes,
    input  logic [3:0]       addr_lo,
    input  logic [SZW-1:0]   beat,
    output logic [3:0]       be_n,
    output logic [1:0]       pa_hi
);
    logic [3:0] offset;
    logic [3:0] pa;
    logic       active;

    assign offset = 4'(beat) << step_shift(width);
    assign pa     = addr_lo + offset;
    assign active = (state == ST_ADDR) || (state == ST_DATA);
    assign be_n   = active ? be_pins(width, lanes, pa[1:0]) : 4'hF;
    assign pa_hi  = active ? pa[3:2] : 2'b00;

    AST_LANES_STEADY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && ($past(state) == ST_DATA || $past(state) == ST_ADDR)
         && width[1]) |-> $stable(be_n)); // R8
endmodule

// File: rtl/mbus_dpath.sv
module mbus_dpath
    import mbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_st_e          state,
    input  logic             accept,
    input  logic             xfer,
    input  logic             write,
    input  logic [DW-1:2]    addr_hi,
    input  logic [SZW-1:0]   last,
    input  logic [SZW-1:0]   beat,
    input  logic [DW-1:0]    ad_in,
    input  logic [NBEAT*DW-1:0] req_wdata,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    output logic [NBEAT*DW-1:0] rdata
);
    logic [NBEAT*DW-1:0] wbuf;

    always_ff @(posedge clk) begin
        if (rst)         wbuf <= '0;
        else if (accept) wbuf <= req_wdata;
    end

    for (genvar s = 0; s < NBEAT; s++) begin : g_slot
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
            if (rst || accept)
                q <= '0;
            else if (xfer && !write && beat == SZW'(s))
                q <= ad_in;
        end
        assign rdata[s*DW +: DW] = q;
    end

    always_comb begin
        ad_out = '0;
        if (state == ST_ADDR)
            ad_out = {addr_hi, last};
        else if (state == ST_DATA && write)
            ad_out = wbuf[beat*DW +: DW];
    end

    assign ad_oe = (state == ST_ADDR) || (state == ST_DATA && write);
endmodule

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
    import mbus_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [DW-1:0]       req_addr,
    input  logic [SZW-1:0]      req_last,
    input  logic [1:0]          req_width,
    input  logic [LANES-1:0]    req_lanes,
    input  logic                req_lock,
    input  logic                req_lock_end,
    input  logic [NBEAT*DW-1:0] req_wdata,
    output logic                done,
    output logic [NBEAT*DW-1:0] rdata,
    input  logic [DW-1:0]       ad_in,
    output logic [DW-1:0]       ad_out,
    output logic                ad_oe,
    output logic                ctl_oe,
    output logic                ads_n,
    output logic                ale,
    output logic [LANES-1:0]    be_n,
    output logic [1:0]          pa_hi,
    output logic                wr,
    output logic                dtr,
    output logic                den_n,
    output logic                blast_n,
    output logic                lock_n,
    input  logic                rdy_n,
    input  logic                hold,
    output logic                holda
);
    req_t           req_in;
    req_t           cur;
    bus_st_e        state;
    logic [SZW-1:0] beat;
    logic           lock_q;
    logic           xfer;
    logic           last_beat;
    logic           accept;
    logic           busy;

    assign req_in = '{write: req_write, lock_end: req_lock_end, width: req_width,
                      last: req_last, lanes: req_lanes, addr: req_addr};
    assign accept = req_valid && req_ready;

    mbus_fsm u_fsm (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_in(req_in),
        .req_lock(req_lock), .rdy_n(rdy_n), .hold(hold), .state(state),
        .beat(beat), .cur(cur), .lock_q(lock_q), .done(done),
        .req_ready(req_ready), .xfer(xfer), .last_beat(last_beat)
    );

    mbus_lane u_lane (
        .state(state), .clk(clk), .rst(rst), .width(cur.width),
        .lanes(cur.lanes), .addr_lo(cur.addr[3:0]), .beat(beat),
        .be_n(be_n), .pa_hi(pa_hi)
    );

    mbus_dpath u_dpath (
        .clk(clk), .rst(rst), .state(state), .accept(accept), .xfer(xfer),
        .write(cur.write), .addr_hi(cur.addr[DW-1:2]), .last(cur.last),
        .beat(beat), .ad_in(ad_in), .req_wdata(req_wdata),
        .ad_out(ad_out), .ad_oe(ad_oe), .rdata(rdata)
    );

    assign busy    = (state == ST_ADDR) || (state == ST_DATA);
    assign ads_n   = !(state == ST_ADDR);
    assign ale     = (state == ST_ADDR);
    assign den_n   = !(state == ST_DATA);
    assign blast_n = !(state == ST_DATA && last_beat);
    assign wr      = busy && cur.write;
    assign dtr     = busy && cur.write;
    assign lock_n  = !(lock_q && !(state == ST_DATA && last_beat && cur.lock_end));
    assign holda   = (state == ST_HOLD);
    assign ctl_oe  = !holda;

    AST_ADDR_THEN_DATA: assert property (@(posedge clk) disable iff (rst)
        !ads_n |=> (!den_n && !ale && ads_n)); // R2
    AST_BLAST_STRETCH: assert property (@(posedge clk) disable iff (rst)
        (!blast_n && rdy_n) |=> !blast_n); // R5
    AST_DIR_STEADY: assert property (@(posedge clk) disable iff (rst)
        (!den_n && !$past(den_n)) |-> $stable(dtr)); // R6
    AST_HOLD_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        holda |-> lock_n); // R9
    AST_HOLD_FLOAT: assert property (@(posedge clk) disable iff (rst)
        holda |-> (!ctl_oe && !ad_oe)); // R10
endmodule

// File: tb/mbus_ctrl_tb.sv
`timescale 1ns/1ps
module mbus_ctrl_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_write = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [1:0]   req_last = '0;
    logic [1:0]   req_width = '0;
    logic [3:0]   req_lanes = '0;
    logic         req_lock = 1'b0;
    logic         req_lock_end = 1'b0;
    logic [127:0] req_wdata = '0;
    logic         done;
    logic [127:0] rdata;
    logic [31:0]  ad_in = '0;
    logic [31:0]  ad_out;
    logic         ad_oe, ctl_oe, ads_n, ale, wr, dtr, den_n, blast_n, lock_n, holda;
    logic [3:0]   be_n;
    logic [1:0]   pa_hi;
    logic         rdy_n = 1'b1;
    logic         hold = 1'b0;

    int total = 0;
    int fails = 0;
    int cyc = 0;

    mbus_ctrl u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_last(req_last),
        .req_width(req_width), .req_lanes(req_lanes), .req_lock(req_lock),
        .req_lock_end(req_lock_end), .req_wdata(req_wdata), .done(done),
        .rdata(rdata), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .ctl_oe(ctl_oe), .ads_n(ads_n), .ale(ale), .be_n(be_n), .pa_hi(pa_hi),
        .wr(wr), .dtr(dtr), .den_n(den_n), .blast_n(blast_n), .lock_n(lock_n),
        .rdy_n(rdy_n), .hold(hold), .holda(holda)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            total = total + 1;
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [1:0]  last;
        logic [1:0]  width;
        logic [3:0]  lanes;
        logic [1:0]  waits;
        logic [1:0]  rec;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h1000_0004, 2'd3, 2'd2, 4'hF, 2'd0, 2'd0},
        '{1'b1, 32'h2000_0008, 2'd1, 2'd2, 4'h3, 2'd2, 2'd2},
        '{1'b0, 32'h3000_0002, 2'd2, 2'd1, 4'h3, 2'd1, 2'd1},
        '{1'b1, 32'h0000_000D, 2'd3, 2'd0, 4'h0, 2'd0, 2'd0},
        '{1'b1, 32'h4000_0006, 2'd0, 2'd1, 4'h1, 2'd3, 2'd0},
        '{1'b0, 32'h5000_0007, 2'd0, 2'd0, 4'h0, 2'd1, 2'd3}
    };

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total = total + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] wword(input int idx, input int k);
        return 32'hA5A5_0000 | 32'(idx << 8) | 32'(k);
    endfunction

    function automatic logic [31:0] rword(input int idx, input int k);
        return 32'hC0DE_0000 | 32'(idx << 8) | 32'(k);
    endfunction

    function automatic logic [3:0] exp_be(input logic [1:0] w, input logic [3:0] ln, input logic [3:0] pa);
        if (w == 2'd0) return {2'b11, pa[1:0]};
        if (w == 2'd1) return {~ln[1], 1'b1, pa[1], ~ln[0]};
        return ~ln;
    endfunction

    function automatic int step_bytes(input logic [1:0] w);
        if (w == 2'd0) return 1;
        if (w == 2'd1) return 2;
        return 4;
    endfunction

    task automatic check_idle_levels(input string tag);
        check({tag, " ads_n"}, ads_n, 1'b1);
        check({tag, " ale"}, ale, 1'b0);
        check({tag, " den_n"}, den_n, 1'b1);
        check({tag, " blast_n"}, blast_n, 1'b1);
        check({tag, " be_n"}, be_n, 4'hF);
        check({tag, " wr/dtr"}, {wr, dtr}, 2'b00);
        check({tag, " holda"}, holda, 1'b0);
        check({tag, " ctl_oe"}, ctl_oe, 1'b1);
        check({tag, " done"}, done, 1'b0);
    endtask

    // Called at a negedge with the bus idle; returns at a negedge in idle.
    task automatic run_txn(input vec_t v, input int idx, input logic lk, input logic lke);
        logic [127:0] exp_rd = '0;
        logic [3:0]   pa;
        for (int k = 0; k < 4; k++) req_wdata[k*32 +: 32] = wword(idx, k);
        req_write = v.wr; req_addr = v.addr; req_last = v.last; req_width = v.width;
        req_lanes = v.lanes; req_lock = lk; req_lock_end = lke; req_valid = 1'b1;
        check("R11 ready in idle", req_ready, 1'b1);
        @(negedge clk);
        req_valid = 1'b0;
        // address cycle
        check("R1 ads_n low", ads_n, 1'b0);
        check("R1 ale high", ale, 1'b1);
        check("R1 address and size", ad_out, {v.addr[31:2], v.last});
        check("R1 ad_oe", ad_oe, 1'b1);
        check("R6 direction in address", {wr, dtr}, {v.wr, v.wr});
        check("R7 be_n in address", be_n, exp_be(v.width, v.lanes, v.addr[3:0]));
        check("R8 pa_hi in address", pa_hi, v.addr[3:2]);
        check("R9 lock in address", lock_n, !lk);
        for (int k = 0; k <= int'(v.last); k++) begin
            pa = v.addr[3:0] + 4'(k * step_bytes(v.width));
            for (int w = 0; w <= int'(v.waits); w++) begin
                @(negedge clk);
                check("R2 ale low in data", ale, 1'b0);
                check("R6 den_n low in data", den_n, 1'b0);
                check("R6 direction in data", dtr, v.wr);
                check("R5 blast_n", blast_n, !(k == int'(v.last)));
                check("R7 be_n in data", be_n, exp_be(v.width, v.lanes, pa));
                check("R8 pa_hi in data", pa_hi, pa[3:2]);
                check("R9 lock in data", lock_n, !(lk && !(lke && k == int'(v.last))));
                check("R10 holda stays low", holda, 1'b0);
                if (v.wr) begin
                    check("R3 write data", ad_out, wword(idx, k));
                    check("R3 write drives bus", ad_oe, 1'b1);
                end else begin
                    check("R3 read floats bus", ad_oe, 1'b0);
                end
                rdy_n = (w < int'(v.waits));
                ad_in = rword(idx, k) ^ 32'(w);
                if (w == int'(v.waits)) exp_rd[k*32 +: 32] = ad_in;
            end
        end
        @(negedge clk);
        check("R11 done pulse", done, 1'b1);
        check("R4 den_n high in recovery", den_n, 1'b1);
        check("R9 lock after sequence step", lock_n, !(lk && !lke));
        if (!v.wr) check("R3 read data", rdata, exp_rd);
        for (int r = 0; r < int'(v.rec); r++) begin
            rdy_n = 1'b0;
            @(negedge clk);
            check("R4 no address in recovery", ads_n, 1'b1);
            check("R4 not ready in recovery", req_ready, 1'b0);
            check("R11 done single cycle", done, 1'b0);
        end
        rdy_n = 1'b1;
        @(negedge clk);
        check("R4 idle after recovery", ads_n, 1'b1);
        check("R11 done low in idle", done, 1'b0);
        if (!hold) check("R4 ready after recovery", req_ready, 1'b1);
        req_lock = 1'b0; req_lock_end = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle_levels("R12 reset");
        check("R12 lock_n reset", lock_n, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        check("R11 ready after reset", req_ready, 1'b1);

        for (int i = 0; i < NV; i++) run_txn(VECS[i], i, 1'b0, 1'b0);

        // Hold and request in the same idle cycle: hold wins, request waits.
        hold = 1'b1;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h6000_0000;
        req_last = 2'd0; req_width = 2'd2; req_lanes = 4'hF;
        @(negedge clk);
        check("R10 holda granted", holda, 1'b1);
        check("R10 controls float", ctl_oe, 1'b0);
        check("R10 bus floats", ad_oe, 1'b0);
        check("R11 not ready in hold", req_ready, 1'b0);
        @(negedge clk);
        check("R11 request pending, no strobe", ads_n, 1'b1);
        hold = 1'b0;
        @(negedge clk);
        check("R10 holda released", holda, 1'b0);
        check("R10 controls driven", ctl_oe, 1'b1);
        check("R11 pending request now ready", req_ready, 1'b1);
        run_txn(VECS[0], 8, 1'b0, 1'b0);

        // Locked sequence with hold pending across it.
        run_txn(VECS[5], 10, 1'b1, 1'b0);
        hold = 1'b1;
        @(negedge clk);
        check("R9 no grant while locked", holda, 1'b0);
        check("R9 lock held between requests", lock_n, 1'b0);
        @(negedge clk);
        check("R9 still no grant", holda, 1'b0);
        run_txn(VECS[1], 11, 1'b1, 1'b1);
        check("R10 no ready with hold pending", req_ready, 1'b0);
        @(negedge clk);
        check("R10 grant after lock release", holda, 1'b1);
        check("R9 unlocked in hold", lock_n, 1'b1);
        hold = 1'b0;
        @(negedge clk);
        check("R10 back to idle", holda, 1'b0);

        // Reset in the middle of a locked burst.
        req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h7000_0000;
        req_last = 2'd3; req_width = 2'd2; req_lanes = 4'hF; req_lock = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_lock = 1'b0; rdy_n = 1'b1;
        @(negedge clk);
        check("R6 in data before reset", den_n, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        check_idle_levels("R12 mid-burst reset");
        check("R12 lock_n mid-burst reset", lock_n, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        check("R12 ready after reset", req_ready, 1'b1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule